// File: doc/BRIEF.md
# Feedback-Updated Branch Direction Table

This block is a direction predictor built from an array of two-bit saturating counters, selected by the fetch address. A lookup returns a taken or not-taken guess together with a small metadata word. The metadata records which slot was consulted and what that slot held at that moment. The pipeline carries this word along with the instruction and does not interpret it.

The table is never written at prediction time. When the branch resolves, the back end returns the metadata on the feedback port, marked either as a confirmation of a correct guess or as a misprediction. The value written back is derived only from that kind and the saved counter, so the slot is overwritten without being read again. A confirmation that arrives twice therefore writes the same value twice and has no further effect.

The lookup read is combinational. Feedback writes at the clock edge, so a lookup in the same cycle as a write sees the old contents.

Top module: `dirpred_table`

## Requirements
- R1: Counter encoding is 2'b00 strong not-taken, 2'b01 weak not-taken, 2'b10 weak taken, 2'b11 strong taken. `lk_taken_o` is bit 1 of the counter held in the looked-up slot. `lk_meta_o[1:0]` carries that counter and `lk_meta_o[META_W-1:2]` carries the slot index, all in the same cycle as `lk_pc_i`.
- R2: The slot index is `lk_pc_i[ALIGN_BITS +: IDX_W]`. All lower and higher address bits have no effect on the lookup.
- R3: After reset, every slot holds weak not-taken (2'b01).
- R4: A lookup never changes the table. When `fb_valid_i` is low, no slot changes.
- R5: A confirmation (`fb_confirm_i`=1) writes the strong state of the direction held in `fb_meta_i[1]` into slot `fb_meta_i[META_W-1:2]`.
- R6: A misprediction (`fb_confirm_i`=0) writes a weak state into the slot. The mapping is 00→01, 11→10, 01→10 and 10→01: strong keeps its direction, weak flips it.
- R7: The written value depends only on the feedback kind and the metadata. Feedback repeated with the same metadata leaves the slot unchanged after the first write.
- R8: A lookup in the same cycle as a write to the same slot returns the old value. The new value is visible from the next cycle.
- R9: At most one slot is written per cycle, and only the slot named by the feedback metadata changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| lk_pc_i | input | PC_W | Fetch address to predict |
| lk_taken_o | output | 1 | Predicted direction, 1 = taken |
| lk_meta_o | output | META_W | Saved slot index and counter for this prediction |
| fb_valid_i | input | 1 | Feedback write strobe, valid-only |
| fb_confirm_i | input | 1 | 1 = prediction was correct, 0 = misprediction |
| fb_meta_i | input | META_W | Metadata returned from the original lookup |

## Verification
The checker relies on feedback metadata having come from an earlier lookup of this table. It also relies on the counter field being any two-bit value and the index lying within the table depth. Because the depth is a power of two, every index value is in range. The bench draws feedback metadata both from the model's current contents and from fully random counters and indices, so it stays inside these assumptions while also covering stale and duplicate feedback. Lookups and feedback are driven in the same cycles, including collisions on one slot.

// File: rtl/dirpred_pkg.sv
package dirpred_pkg;

   typedef enum logic [1:0] {
      CTR_STRONG_NT = 2'b00,
      CTR_WEAK_NT   = 2'b01,
      CTR_WEAK_T    = 2'b10,
      CTR_STRONG_T  = 2'b11
   } ctr_t;

   localparam ctr_t CTR_RESET = CTR_WEAK_NT;

   // strong state in the saved direction
   function automatic ctr_t ctr_on_confirm(input ctr_t old);
      return old[1] ? CTR_STRONG_T : CTR_STRONG_NT;
   endfunction

   // weak state; a weak old value flips direction
   function automatic ctr_t ctr_on_redirect(input ctr_t old);
      ctr_t res;
      unique case (old)
         CTR_STRONG_NT: res = CTR_WEAK_NT;
         CTR_WEAK_NT:   res = CTR_WEAK_T;
         CTR_WEAK_T:    res = CTR_WEAK_NT;
         default:       res = CTR_WEAK_T;
      endcase
      return res;
   endfunction

endpackage

// File: rtl/dirpred_index.sv
module dirpred_index #(
   parameter int PC_W       = 39,
   parameter int ALIGN_BITS = 2,
   parameter int IDX_W      = 6
) (
   input  logic [PC_W-1:0]  pc_i,
   output logic [IDX_W-1:0] idx_o
);
   localparam int TOP_BIT = ALIGN_BITS + IDX_W;

   assign idx_o = pc_i[ALIGN_BITS +: IDX_W];

   generate
      if (ALIGN_BITS > 0) begin : g_low
         logic low_unused;
         assign low_unused = ^pc_i[ALIGN_BITS-1:0];
      end
      if (PC_W > TOP_BIT) begin : g_high
         logic high_unused;
         assign high_unused = ^pc_i[PC_W-1:TOP_BIT];
      end
   endgenerate
endmodule

// File: rtl/dirpred_next.sv
module dirpred_next
   import dirpred_pkg::*;
(
   input  logic       confirm_i,
   input  logic [1:0] old_i,
   output logic [1:0] new_o
);
   ctr_t old_c;
   assign old_c = ctr_t'(old_i);

   always_comb begin
      if (confirm_i) new_o = ctr_on_confirm(old_c);
      else           new_o = ctr_on_redirect(old_c);
   end
endmodule

// File: rtl/dirpred_regfile.sv
module dirpred_regfile
   import dirpred_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IDX_W = 6
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               we_i,
   input  logic [IDX_W-1:0]   widx_i,
   input  logic [1:0]         wdata_i,
   input  logic [IDX_W-1:0]   ridx_i,
   output logic [1:0]         rdata_o,
   output logic [2*DEPTH-1:0] flat_o
);
   ctr_t slot_q [DEPTH];

   genvar g;
   generate
      for (g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk_i) begin
            if (!rst_ni)
               slot_q[g] <= CTR_RESET;
            else if (we_i && (widx_i == IDX_W'(g)))
               slot_q[g] <= ctr_t'(wdata_i);
         end
         assign flat_o[2*g +: 2] = slot_q[g];
      end
   endgenerate

   assign rdata_o = slot_q[ridx_i];
endmodule

// File: rtl/dirpred_table.sv
module dirpred_table #(
   parameter int PC_W       = 39,
   parameter int ALIGN_BITS = 2,
   parameter int DEPTH      = 64,
   parameter int IDX_W      = $clog2(DEPTH),
   parameter int META_W     = IDX_W + 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [PC_W-1:0]   lk_pc_i,
   output logic              lk_taken_o,
   output logic [META_W-1:0] lk_meta_o,
   input  logic              fb_valid_i,
   input  logic              fb_confirm_i,
   input  logic [META_W-1:0] fb_meta_i
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (IDX_W != $clog2(DEPTH) || META_W != IDX_W + 2) begin : g_bad_widths
         $error("IDX_W and META_W must follow from DEPTH");
      end
      if (PC_W < ALIGN_BITS + IDX_W) begin : g_bad_pc
         $error("PC_W too narrow for the index field");
      end
   endgenerate

   logic [IDX_W-1:0]   rd_idx;
   logic [1:0]         rd_ctr;
   logic [IDX_W-1:0]   wr_idx;
   logic [1:0]         wr_old;
   logic [1:0]         wr_new;
   logic [2*DEPTH-1:0] ctr_flat;

   dirpred_index #(
      .PC_W(PC_W), .ALIGN_BITS(ALIGN_BITS), .IDX_W(IDX_W)
   ) u_index (
      .pc_i (lk_pc_i),
      .idx_o(rd_idx)
   );

   assign wr_idx = fb_meta_i[META_W-1:2];
   assign wr_old = fb_meta_i[1:0];

   dirpred_next u_next (
      .confirm_i(fb_confirm_i),
      .old_i    (wr_old),
      .new_o    (wr_new)
   );

   dirpred_regfile #(
      .DEPTH(DEPTH), .IDX_W(IDX_W)
   ) u_rf (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (fb_valid_i),
      .widx_i (wr_idx),
      .wdata_i(wr_new),
      .ridx_i (rd_idx),
      .rdata_o(rd_ctr),
      .flat_o (ctr_flat)
   );

   assign lk_taken_o = rd_ctr[1];
   assign lk_meta_o  = {rd_idx, rd_ctr};
endmodule

// File: rtl/dirpred_table_chk.sv
module dirpred_table_chk #(
   parameter int DEPTH  = 64,
   parameter int IDX_W  = 6,
   parameter int META_W = 8
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               lk_taken_o,
   input logic [META_W-1:0]  lk_meta_o,
   input logic               fb_valid_i,
   input logic               fb_confirm_i,
   input logic [META_W-1:0]  fb_meta_i,
   input logic [2*DEPTH-1:0] ctr_flat
);
   logic               last_v;
   logic               last_conf;
   logic [IDX_W-1:0]   last_idx;
   logic [1:0]         last_ctr;
   logic [2*DEPTH-1:0] prev_flat;
   logic [1:0]         slot_now;
   logic [1:0]         read_slot;
   logic [2*DEPTH-1:0] mask_keep;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         last_v    <= 1'b0;
         last_conf <= 1'b0;
         last_idx  <= '0;
         last_ctr  <= '0;
      end else begin
         last_v    <= fb_valid_i;
         last_conf <= fb_confirm_i;
         last_idx  <= fb_meta_i[META_W-1:2];
         last_ctr  <= fb_meta_i[1:0];
      end
      prev_flat <= ctr_flat;
   end

   always_comb begin
      slot_now  = ctr_flat[2*last_idx +: 2];
      read_slot = ctr_flat[2*lk_meta_o[META_W-1:2] +: 2];
      mask_keep = '1;
      mask_keep[2*last_idx +: 2] = 2'b00;
   end

   // R5
   confirm_strong_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (last_v && last_conf) |-> (slot_now == {last_ctr[1], last_ctr[1]}));

   // R6
   redirect_weak_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (last_v && !last_conf) |-> (slot_now[1] != slot_now[0]));

   // R6
   redirect_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (last_v && !last_conf) |-> (slot_now[1] == (last_ctr[1] ^ (last_ctr[1] != last_ctr[0]))));

   // R4
   idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!last_v && $past(rst_ni)) |-> (ctr_flat == prev_flat));

   // R9
   other_slots_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (last_v && $past(rst_ni)) |-> ((ctr_flat & mask_keep) == (prev_flat & mask_keep)));

   // R1
   read_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lk_meta_o[1:0] == read_slot) && (lk_taken_o == read_slot[1]));
endmodule

bind dirpred_table dirpred_table_chk #(
   .DEPTH(DEPTH), .IDX_W(IDX_W), .META_W(META_W)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .lk_taken_o  (lk_taken_o),
   .lk_meta_o   (lk_meta_o),
   .fb_valid_i  (fb_valid_i),
   .fb_confirm_i(fb_confirm_i),
   .fb_meta_i   (fb_meta_i),
   .ctr_flat    (ctr_flat)
);

// File: tb/sim_dirpred_table.sv
module sim_dirpred_table;
   localparam int PC_W   = 39;
   localparam int ALIGN  = 2;
   localparam int DEPTH  = 16;
   localparam int IDX_W  = 4;
   localparam int META_W = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [PC_W-1:0]   pc = '0;
   logic              taken;
   logic [META_W-1:0] meta;
   logic              fbv = 1'b0;
   logic              fbc = 1'b0;
   logic [META_W-1:0] fbm = '0;

   int errors = 0;
   int checks = 0;
   int model [DEPTH];

   always #4 clk = ~clk;

   dirpred_table #(
      .PC_W(PC_W), .ALIGN_BITS(ALIGN), .DEPTH(DEPTH)
   ) u0 (
      .clk_i(clk), .rst_ni(rst_n), .lk_pc_i(pc), .lk_taken_o(taken),
      .lk_meta_o(meta), .fb_valid_i(fbv), .fb_confirm_i(fbc), .fb_meta_i(fbm)
   );

   function automatic int next_val(input bit conf, input int old);
      if (conf) return (old >= 2) ? 3 : 0;
      case (old)
         0: return 1;
         1: return 2;
         2: return 1;
         default: return 2;
      endcase
   endfunction

   function automatic logic [PC_W-1:0] pc_of(input int idx, input int salt);
      logic [PC_W-1:0] p;
      p = {PC_W{1'b0}};
      p[ALIGN +: IDX_W] = IDX_W'(idx);
      p[ALIGN-1:0] = ALIGN'(salt);
      p[PC_W-1 -: 8] = 8'(salt * 37);
      return p;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // drive one cycle: lookup plus optional feedback, compare against model
   task automatic step(input logic [PC_W-1:0] p, input bit v, input bit c,
                       input int fidx, input int fctr, input string tag);
      int ridx;
      pc  = p;
      fbv = v;
      fbc = c;
      fbm = {IDX_W'(fidx), 2'(fctr)};
      #1;
      ridx = int'(p[ALIGN +: IDX_W]);
      check(tag, int'(meta), ridx * 4 + model[ridx]);
      check(tag, int'(taken), model[ridx] / 2);
      @(posedge clk);
      if (v) model[fidx] = next_val(c, fctr);
      @(negedge clk);
      fbv = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R3: every slot weak not-taken after reset
      for (int i = 0; i < DEPTH; i++) step(pc_of(i, 0), 0, 0, 0, 0, "R3 reset");

      // R5: confirmation makes strong in saved direction
      step(pc_of(3, 1), 1, 1, 3, 1, "R5 confirm");
      step(pc_of(3, 2), 0, 0, 0, 0, "R5 readback nt");
      step(pc_of(4, 0), 1, 1, 4, 2, "R5 confirm");
      step(pc_of(4, 3), 0, 0, 0, 0, "R5 readback t");

      // R6: all four redirect transitions
      step(pc_of(3, 0), 1, 0, 3, 0, "R6 00");
      step(pc_of(3, 0), 1, 0, 3, 1, "R6 01");
      step(pc_of(3, 0), 1, 0, 3, 3, "R6 11");
      step(pc_of(3, 0), 1, 0, 3, 2, "R6 10");
      step(pc_of(3, 0), 0, 0, 0, 0, "R6 readback");

      // R7: duplicate confirmations leave slot as after the first
      for (int k = 0; k < 3; k++) step(pc_of(5, k), 1, 1, 5, 2, "R7 dup");
      step(pc_of(5, 1), 0, 0, 0, 0, "R7 readback");

      // R8: same-cycle lookup and write to one slot sees old value
      step(pc_of(7, 0), 1, 1, 7, 3, "R8 collide");
      step(pc_of(7, 0), 0, 0, 0, 0, "R8 next cycle");

      // R2: low and high address bits do not affect the slot
      for (int s = 0; s < 4; s++) step(pc_of(4, s), 0, 0, 0, 0, "R2 alias");

      // R4: lookups without feedback never change any slot
      for (int i = 0; i < DEPTH; i++) step(pc_of(i, i), 0, 1, i, 3, "R4 idle");

      // R7/R9: random traffic, stale and fresh metadata
      for (int n = 0; n < 400; n++) begin
         int fi;
         int fc;
         fi = $urandom_range(DEPTH - 1);
         fc = ($urandom_range(3) == 0) ? $urandom_range(3) : model[fi];
         step(pc_of($urandom_range(DEPTH - 1), $urandom_range(255)),
              bit'($urandom_range(1)), bit'($urandom_range(1)), fi, fc, "R9 random");
      end
      for (int i = 0; i < DEPTH; i++) step(pc_of(i, 0), 0, 0, 0, 0, "R9 sweep");

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule